// File: doc/BRIEF.md
# Branch Resolve and Next-PC Unit

This unit sits beside the fetch stage of a 32-bit core with fixed four-byte instructions. Each cycle the decoder hands it the address of the instruction being resolved, a transfer kind, two register operand values, a 16-bit branch displacement, a 26-bit jump index and a register-held jump address. The unit decides whether control leaves the sequential path. It chooses the next fetch address. For the linking transfer kinds, it also asks for a write of the return address into register 31.

The core exposes a single delay slot. The instruction that follows a taken transfer always runs, and the redirect reaches the fetch address only after that instruction. A one-entry pending-redirect register holds the resolved target until the slot instruction is presented as valid. Branch conditions test two registers for equality or inequality, or test one register against zero as a two's-complement value. The core has no condition flags.

Top module: `npc_resolve`

## Requirements
- R1: While `rst_n` is low, and for two rising edges after it rises, no redirect is pending and `next_pc` equals `cur_pc + 4`. Asserting `rst_n` while a redirect is pending clears it at once.
- R2: `xfer_kind` codes are 0 none, 1 equal, 2 not-equal, 3 less-or-equal-zero, 4 greater-than-zero, 5 less-than-zero, 6 greater-or-equal-zero, 7 less-than-zero-and-link, 8 greater-or-equal-zero-and-link, 9 jump, 10 jump-and-link, 11 jump-register. Codes 12 to 15 act as code 0. Codes 9 to 11 are always taken and code 0 is never taken. `take` is 0 whenever `inst_vld` is 0.
- R3: Code 1 is taken when `opa == opb`. Code 2 is taken when they differ.
- R4: Codes 3 to 8 compare `opa` against zero as a signed 32-bit value. `opb` has no effect on them.
- R5: The target of a conditional branch is `cur_pc + 4 + (sign-extended br_off << 2)`.
- R6: The target of codes 9 and 10 is bits 31:28 of `cur_pc + 4`, followed by `jmp_idx`, followed by two zero bits. The target of code 11 is `jr_val` unchanged.
- R7: In the cycle that resolves a taken transfer, `next_pc` is `cur_pc + 4` (the delay slot). In the next cycle with `inst_vld` high, `next_pc` is the stored target. After that cycle the pending redirect is gone.
- R8: A pending redirect is held, and `next_pc` keeps showing its target, through any number of cycles with `inst_vld` low.
- R9: With `inst_vld` high, codes 7, 8 and 10 raise `link_we` whether or not they are taken. They drive `link_rd` = 31 and `link_val` = `cur_pc + 8`. Every other code leaves `link_we` low.
- R10: A taken transfer resolved in a delay slot does not replace the stored target. Once the slot is consumed, no redirect remains, and the following instruction sees `next_pc` = `cur_pc + 4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| inst_vld | input | 1 | The presented instruction is valid this cycle |
| cur_pc | input | 32 | Address of the instruction being resolved |
| xfer_kind | input | 4 | Decoded transfer kind (codes in R2) |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand |
| br_off | input | 16 | Branch displacement in instruction words |
| jmp_idx | input | 26 | Jump index field |
| jr_val | input | 32 | Register value for jump-register |
| next_pc | output | 32 | Address to fetch next |
| take | output | 1 | The resolved transfer is taken |
| link_we | output | 1 | Request to write the return address |
| link_rd | output | 5 | Destination register of the link write (31) |
| link_val | output | 32 | Return address, `cur_pc + 8` |

## Verification
The assertions assume that the decode inputs settle before each rising edge and stay known after reset. They also assume that the fetch side eventually presents a valid delay-slot instruction after every taken transfer, so the pending register does not stay occupied forever. The bench changes inputs only on falling clock edges and samples one nanosecond later. It follows every taken transfer with a valid slot instruction. The two exceptions are the hold scenario, which first inserts idle cycles, and the reset scenario, which clears the pending redirect through the reset pin.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    XF_NONE    = 4'd0,
    XF_BEQ     = 4'd1,
    XF_BNE     = 4'd2,
    XF_BLEZ    = 4'd3,
    XF_BGTZ    = 4'd4,
    XF_BLTZ    = 4'd5,
    XF_BGEZ    = 4'd6,
    XF_BLTZ_LK = 4'd7,
    XF_BGEZ_LK = 4'd8,
    XF_JUMP    = 4'd9,
    XF_JUMP_LK = 4'd10,
    XF_JREG    = 4'd11
  } xfer_kind_e;

  // which target former feeds the redirect
  typedef enum logic [1:0] {
    TG_REL  = 2'd0,
    TG_IDX  = 2'd1,
    TG_REG  = 2'd2
  } tgt_sel_e;

endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]      kind,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            cond_take,
  output logic            link_req,
  output tgt_sel_e        tgt_sel
);

  logic a_zero;
  logic a_neg;
  logic ab_eq;

  assign a_zero = (opa == '0);
  assign a_neg  = opa[XLEN-1];
  assign ab_eq  = (opa == opb);

  always_comb begin
    cond_take = 1'b0;
    link_req  = 1'b0;
    tgt_sel   = TG_REL;
    case (kind)
      XF_BEQ:     cond_take = ab_eq;
      XF_BNE:     cond_take = !ab_eq;
      XF_BLEZ:    cond_take = a_neg || a_zero;
      XF_BGTZ:    cond_take = !a_neg && !a_zero;
      XF_BLTZ:    cond_take = a_neg;
      XF_BGEZ:    cond_take = !a_neg;
      XF_BLTZ_LK: begin
        cond_take = a_neg;
        link_req  = 1'b1;
      end
      XF_BGEZ_LK: begin
        cond_take = !a_neg;
        link_req  = 1'b1;
      end
      XF_JUMP: begin
        cond_take = 1'b1;
        tgt_sel   = TG_IDX;
      end
      XF_JUMP_LK: begin
        cond_take = 1'b1;
        link_req  = 1'b1;
        tgt_sel   = TG_IDX;
      end
      XF_JREG: begin
        cond_take = 1'b1;
        tgt_sel   = TG_REG;
      end
      default: begin
        cond_take = 1'b0;
        link_req  = 1'b0;
        tgt_sel   = TG_REL;
      end
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int OFF_W      = 16,
  parameter int IDX_W      = 26,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  jr_val,
  input  tgt_sel_e         sel,
  output logic [XLEN-1:0]  pc_seq,
  output logic [XLEN-1:0]  pc_link,
  output logic [XLEN-1:0]  tgt
);

  localparam int SH     = $clog2(INSN_BYTES);
  localparam int EXT_W  = XLEN - OFF_W - SH;
  localparam int HI_W   = XLEN - IDX_W - SH;

  logic [XLEN-1:0] disp;
  logic [XLEN-1:0] rel_tgt;
  logic [XLEN-1:0] idx_tgt;

  assign pc_seq  = pc + XLEN'(INSN_BYTES);
  assign pc_link = pc + XLEN'(2 * INSN_BYTES);

  generate
    if (SH > 0) begin : g_scaled
      assign disp    = {{EXT_W{off[OFF_W-1]}}, off, {SH{1'b0}}};
      assign idx_tgt = {pc_seq[XLEN-1 -: HI_W], idx, {SH{1'b0}}};
    end else begin : g_byte
      assign disp    = {{EXT_W{off[OFF_W-1]}}, off};
      assign idx_tgt = {pc_seq[XLEN-1 -: HI_W], idx};
    end
  endgenerate

  assign rel_tgt = pc_seq + disp;

  always_comb begin
    case (sel)
      TG_IDX:  tgt = idx_tgt;
      TG_REG:  tgt = jr_val;
      default: tgt = rel_tgt;
    endcase
  end

endmodule

// File: rtl/npc_redirect.sv
module npc_redirect #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inst_vld,
  input  logic            taken,
  input  logic [XLEN-1:0] tgt_in,
  output logic            pend_vld,
  output logic [XLEN-1:0] pend_tgt
);

  logic            consume;
  logic            fire;
  logic            vld_d;
  logic            tgt_en;
  logic [XLEN-1:0] tgt_d;

  // a valid instruction while pending is the delay slot
  assign consume = inst_vld && pend_vld;
  assign fire    = inst_vld && taken && !pend_vld;

  always_comb begin
    vld_d  = pend_vld;
    tgt_en = 1'b0;
    tgt_d  = pend_tgt;
    if (consume) begin
      vld_d = 1'b0;
    end else if (fire) begin
      vld_d  = 1'b1;
      tgt_en = 1'b1;
      tgt_d  = tgt_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
    end else begin
      pend_vld <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (tgt_en) begin
      pend_tgt <= tgt_d;
    end
  end

  // R7
  slot_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_vld && pend_vld) |=> !pend_vld);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inst_vld && pend_vld) |=> (pend_vld && $stable(pend_tgt)));

endmodule

// File: rtl/npc_resolve.sv
module npc_resolve
  import npc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int OFF_W      = 16,
  parameter int IDX_W      = 26,
  parameter int INSN_BYTES = 4,
  parameter int RA_W       = 5,
  parameter int LINK_REG   = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inst_vld,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [3:0]       xfer_kind,
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  input  logic [OFF_W-1:0] br_off,
  input  logic [IDX_W-1:0] jmp_idx,
  input  logic [XLEN-1:0]  jr_val,
  output logic [XLEN-1:0]  next_pc,
  output logic             take,
  output logic             link_we,
  output logic [RA_W-1:0]  link_rd,
  output logic [XLEN-1:0]  link_val
);

  logic [1:0]      rst_sync;
  logic            rst_ok;
  logic            cond_take;
  logic            link_req;
  tgt_sel_e        tgt_sel;
  logic [XLEN-1:0] pc_seq;
  logic [XLEN-1:0] pc_link;
  logic [XLEN-1:0] xfer_tgt;
  logic            pend_vld;
  logic [XLEN-1:0] pend_tgt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_ok = rst_sync[1];

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind      (xfer_kind),
    .opa       (opa),
    .opb       (opb),
    .cond_take (cond_take),
    .link_req  (link_req),
    .tgt_sel   (tgt_sel)
  );

  npc_target #(
    .XLEN       (XLEN),
    .OFF_W      (OFF_W),
    .IDX_W      (IDX_W),
    .INSN_BYTES (INSN_BYTES)
  ) u_tgt (
    .pc      (cur_pc),
    .off     (br_off),
    .idx     (jmp_idx),
    .jr_val  (jr_val),
    .sel     (tgt_sel),
    .pc_seq  (pc_seq),
    .pc_link (pc_link),
    .tgt     (xfer_tgt)
  );

  npc_redirect #(.XLEN(XLEN)) u_redir (
    .clk      (clk),
    .rst_n    (rst_ok),
    .inst_vld (inst_vld),
    .taken    (cond_take),
    .tgt_in   (xfer_tgt),
    .pend_vld (pend_vld),
    .pend_tgt (pend_tgt)
  );

  assign take     = inst_vld && cond_take;
  assign link_we  = inst_vld && link_req;
  assign link_rd  = RA_W'(LINK_REG);
  assign link_val = pc_link;
  assign next_pc  = pend_vld ? pend_tgt : pc_seq;

  // R7
  delay_slot_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (take && !pend_vld) |-> (next_pc == cur_pc + XLEN'(INSN_BYTES)));

  // R7
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (take && !pend_vld) |=> (next_pc == $past(xfer_tgt)));

  // R2
  uncond_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (inst_vld && (xfer_kind == XF_JUMP || xfer_kind == XF_JUMP_LK ||
                  xfer_kind == XF_JREG)) |-> take);

  // R9
  link_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    link_we |-> (link_rd == RA_W'(LINK_REG) &&
                 link_val == cur_pc + XLEN'(2 * INSN_BYTES)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !inst_vld |-> (!take && !link_we));

endmodule

// File: tb/sim_npc_resolve.sv
`timescale 1ns/100ps
module sim_npc_resolve;
  import npc_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        inst_vld;
  logic [31:0] cur_pc;
  logic [3:0]  xfer_kind;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [15:0] br_off;
  logic [25:0] jmp_idx;
  logic [31:0] jr_val;
  logic [31:0] next_pc;
  logic        take;
  logic        link_we;
  logic [4:0]  link_rd;
  logic [31:0] link_val;

  int checks = 0;
  int errors = 0;

  npc_resolve u0 (
    .clk(clk), .rst_n(rst_n), .inst_vld(inst_vld), .cur_pc(cur_pc),
    .xfer_kind(xfer_kind), .opa(opa), .opb(opb), .br_off(br_off),
    .jmp_idx(jmp_idx), .jr_val(jr_val), .next_pc(next_pc), .take(take),
    .link_we(link_we), .link_rd(link_rd), .link_val(link_val)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit ref_take(input logic [3:0] k,
                                  input logic [31:0] a, input logic [31:0] b);
    case (k)
      4'd1:  return a == b;
      4'd2:  return a != b;
      4'd3:  return $signed(a) <= 0;
      4'd4:  return $signed(a) > 0;
      4'd5, 4'd7: return $signed(a) < 0;
      4'd6, 4'd8: return $signed(a) >= 0;
      4'd9, 4'd10, 4'd11: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] ref_tgt(input logic [3:0] k, input logic [31:0] pc,
      input logic [15:0] off, input logic [25:0] idx, input logic [31:0] jr);
    logic [31:0] p4;
    p4 = pc + 32'd4;
    if (k == 4'd9 || k == 4'd10) return {p4[31:28], idx, 2'b00};
    if (k == 4'd11) return jr;
    return p4 + (32'($signed(off)) <<< 2);
  endfunction

  function automatic bit ref_link(input logic [3:0] k);
    return k == 4'd7 || k == 4'd8 || k == 4'd10;
  endfunction

  task automatic drive(input bit v, input logic [3:0] k, input logic [31:0] pc,
      input logic [31:0] a, input logic [31:0] b, input logic [15:0] off,
      input logic [25:0] idx, input logic [31:0] jr);
    @(negedge clk);
    inst_vld = v; xfer_kind = k; cur_pc = pc; opa = a; opb = b;
    br_off = off; jmp_idx = idx; jr_val = jr;
    #1;
  endtask

  // resolve one transfer, then present its delay slot
  task automatic xfer(input string req, input logic [3:0] k, input logic [31:0] pc,
      input logic [31:0] a, input logic [31:0] b, input logic [15:0] off,
      input logic [25:0] idx, input logic [31:0] jr);
    bit t;
    logic [31:0] tg;
    t  = ref_take(k, a, b);
    tg = ref_tgt(k, pc, off, idx, jr);
    drive(1'b1, k, pc, a, b, off, idx, jr);
    chk(take == t, {req, " take"}, 32'(take), 32'(t));
    chk(next_pc == pc + 32'd4, "R7 slot fetch", next_pc, pc + 32'd4);
    chk(link_we == ref_link(k), "R9 link_we", 32'(link_we), 32'(ref_link(k)));
    if (ref_link(k)) begin
      chk(link_rd == 5'd31, "R9 link_rd", 32'(link_rd), 32'd31);
      chk(link_val == pc + 32'd8, "R9 link_val", link_val, pc + 32'd8);
    end
    drive(1'b1, 4'd0, pc + 32'd4, 32'd0, 32'd0, 16'd0, 26'd0, 32'd0);
    chk(next_pc == (t ? tg : pc + 32'd8), {req, " target"}, next_pc,
        t ? tg : pc + 32'd8);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    inst_vld = 1'b0; xfer_kind = 4'd0; cur_pc = 32'h100; opa = '0; opb = '0;
    br_off = '0; jmp_idx = '0; jr_val = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(next_pc == 32'h104, "R1 reset next_pc", next_pc, 32'h104);
    chk(!take && !link_we, "R1 reset quiet", {30'd0, take, link_we}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_equality;
    xfer("R3 beq equal", 4'd1, 32'h1000, 32'd5, 32'd5, 16'd3, 26'd0, 32'd0);
    xfer("R3 beq differ", 4'd1, 32'h1000, 32'd5, 32'd6, 16'd3, 26'd0, 32'd0);
    xfer("R3 bne differ", 4'd2, 32'h2000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 16'd1, 26'd0, 32'd0);
    xfer("R3 bne equal", 4'd2, 32'h2000, 32'd9, 32'd9, 16'd1, 26'd0, 32'd0);
  endtask

  task automatic t_zero;
    // opb set to values that would flip an equality test: R4 says no effect
    xfer("R4 blez zero", 4'd3, 32'h3000, 32'd0, 32'd1, 16'd2, 26'd0, 32'd0);
    xfer("R4 blez pos", 4'd3, 32'h3000, 32'd1, 32'd1, 16'd2, 26'd0, 32'd0);
    xfer("R4 bgtz min", 4'd4, 32'h3000, 32'h8000_0000, 32'd0, 16'd2, 26'd0, 32'd0);
    xfer("R4 bgtz max", 4'd4, 32'h3000, 32'h7FFF_FFFF, 32'd0, 16'd2, 26'd0, 32'd0);
    xfer("R4 bltz neg1", 4'd5, 32'h3000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'd2, 26'd0, 32'd0);
    xfer("R4 bltz zero", 4'd5, 32'h3000, 32'd0, 32'd7, 16'd2, 26'd0, 32'd0);
    xfer("R4 bgez zero", 4'd6, 32'h3000, 32'd0, 32'd7, 16'd2, 26'd0, 32'd0);
    xfer("R4 bgez neg", 4'd6, 32'h3000, 32'h8000_0000, 32'd7, 16'd2, 26'd0, 32'd0);
  endtask

  task automatic t_offsets;
    xfer("R5 offset minus one", 4'd1, 32'h4000, 32'd0, 32'd0, 16'hFFFF, 26'd0, 32'd0);
    xfer("R5 offset most negative", 4'd1, 32'h0004_0000, 32'd0, 32'd0, 16'h8000, 26'd0, 32'd0);
    xfer("R5 offset most positive", 4'd1, 32'h4000, 32'd0, 32'd0, 16'h7FFF, 26'd0, 32'd0);
  endtask

  task automatic t_jumps;
    xfer("R6 jump region", 4'd9, 32'hA000_0010, 32'd0, 32'd0, 16'h0, 26'h3FF_FFFF, 32'd0);
    xfer("R6 jump region carry", 4'd9, 32'h0FFF_FFFC, 32'd0, 32'd0, 16'h0, 26'h000_0040, 32'd0);
    xfer("R6 jump register", 4'd11, 32'h5000, 32'd0, 32'd0, 16'h0, 26'd0, 32'hDEAD_BEE0);
    xfer("R2 unknown code", 4'd13, 32'h5000, 32'd0, 32'd0, 16'h4, 26'd5, 32'h0);
    xfer("R2 none", 4'd0, 32'h5000, 32'd0, 32'd0, 16'h4, 26'd5, 32'h0);
  endtask

  task automatic t_links;
    xfer("R9 bltzal not taken", 4'd7, 32'h6000, 32'd4, 32'd0, 16'h10, 26'd0, 32'd0);
    xfer("R9 bltzal taken", 4'd7, 32'h6000, 32'hFFFF_FFF0, 32'd0, 16'h10, 26'd0, 32'd0);
    xfer("R9 bgezal taken", 4'd8, 32'h6100, 32'd0, 32'd0, 16'hFFF0, 26'd0, 32'd0);
    xfer("R9 jal", 4'd10, 32'h6200, 32'd0, 32'd0, 16'h0, 26'h12_3456, 32'd0);
  endtask

  task automatic t_hold;
    logic [31:0] tg;
    tg = ref_tgt(4'd2, 32'h7000, 16'h20, 26'd0, 32'd0);
    drive(1'b1, 4'd2, 32'h7000, 32'd1, 32'd2, 16'h20, 26'd0, 32'd0);
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 4'd9, 32'h7004, 32'd0, 32'd0, 16'h0, 26'd0, 32'd0);
      chk(next_pc == tg, "R8 hold while idle", next_pc, tg);
      chk(!take && !link_we, "R2 idle quiet", {30'd0, take, link_we}, 32'd0);
    end
    drive(1'b1, 4'd0, 32'h7004, 32'd0, 32'd0, 16'h0, 26'd0, 32'd0);
    chk(next_pc == tg, "R8 slot after idle", next_pc, tg);
    drive(1'b1, 4'd0, tg, 32'd0, 32'd0, 16'h0, 26'd0, 32'd0);
    chk(next_pc == tg + 32'd4, "R7 cleared after slot", next_pc, tg + 32'd4);
  endtask

  task automatic t_slot_xfer;
    logic [31:0] tg;
    tg = ref_tgt(4'd1, 32'h8000, 16'h8, 26'd0, 32'd0);
    drive(1'b1, 4'd1, 32'h8000, 32'd3, 32'd3, 16'h8, 26'd0, 32'd0);
    drive(1'b1, 4'd9, 32'h8004, 32'd0, 32'd0, 16'h0, 26'h00_0100, 32'd0);
    chk(next_pc == tg, "R10 first target kept", next_pc, tg);
    drive(1'b1, 4'd0, tg, 32'd0, 32'd0, 16'h0, 26'd0, 32'd0);
    chk(next_pc == tg + 32'd4, "R10 no second redirect", next_pc, tg + 32'd4);
  endtask

  task automatic t_reset_pending;
    drive(1'b1, 4'd9, 32'h9000, 32'd0, 32'd0, 16'h0, 26'h00_0200, 32'd0);
    @(negedge clk);
    inst_vld = 1'b0;
    cur_pc = 32'h9004;
    rst_n = 1'b0;
    #1;
    chk(next_pc == 32'h9008, "R1 reset clears pending", next_pc, 32'h9008);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    drive(1'b1, 4'd0, 32'h9004, 32'd0, 32'd0, 16'h0, 26'd0, 32'd0);
    chk(next_pc == 32'h9008, "R1 no redirect after reset", next_pc, 32'h9008);
  endtask

  initial begin
    t_reset();
    t_equality();
    t_zero();
    t_offsets();
    t_jumps();
    t_links();
    t_hold();
    t_slot_xfer();
    t_reset_pending();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule